// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor's load/store port and the next memory level. It holds a fixed number of lines, each several 32-bit words wide. Every line carries a valid flag and a stored address tag. The cache is direct mapped: each memory block has exactly one line it can occupy, and that line is picked by the block address modulo the line count. A load that finds its line valid, with a matching tag, is answered from the cache. A load that misses stalls the processor while the whole line is fetched from the next level, one word per beat. The line is then marked valid and the requested word is returned.

Stores are written through to the next level on every access. A store that hits also updates the cached word. A store that misses leaves the cache contents untouched (no allocation on write). The write buffer and the memory timing behind the next-level ports belong to other blocks. Two free-running counters record lookup hits and misses, so miss behaviour can be measured on reference address strings.

Top module: `dmc_cache`

## Requirements
- R1: A byte address splits into byte offset [1:0] (ignored for word accesses), word select [WSEL_W+1:2], line index [INDEX_W+WSEL_W+1:WSEL_W+2] and tag (all bits above). With the defaults (WSEL_W=2, INDEX_W=8) these are [3:2], [11:4] and the 20 bits [31:12].
- R2: After reset `cpu_ready` is 1, `cpu_rvalid`, `mem_rd_req` and `mem_wr_valid` are 0, both counters are 0, and every line is invalid, so the first access to any line misses.
- R3: A request is accepted on a clock edge where `cpu_req` and `cpu_ready` are both 1. For a read hit, `cpu_rvalid` is 1 for exactly one cycle after the second edge from acceptance, with the cached word on `cpu_rdata`, and `hit_count` increments.
- R4: For a read miss, `mem_rd_req` pulses for one cycle after the second edge from acceptance, with `mem_rd_addr` set to the line-aligned byte address (word-select and byte-offset bits zero). `miss_count` increments, and `cpu_ready` stays 0 until the response.
- R5: Refill beats arrive on `mem_rd_valid`, with the word position in the line on `mem_rd_word` (0..2^WSEL_W-1). They may come in any order and with idle cycles between them. The read response is given after the edge that takes the last beat, and only then does the line become valid.
- R6: A write hit updates the cached word. After the second edge from acceptance, `mem_wr_valid` pulses for one cycle, with `mem_wr_addr` equal to the request address with bits [1:0] cleared and `mem_wr_data` equal to the store data. A later read of that word hits and returns the new value.
- R7: A write miss is forwarded to the next level exactly as in R6 but does not allocate. The line at that index keeps its old tag and stays valid, and a later read of the written word misses.
- R8: Addresses with the same index but different tags evict each other. Alternating reads of two such blocks miss on every access.
- R9: Each lookup (read or write) increments exactly one of `hit_count` or `miss_count`. In a two-line, two-word configuration, the read string of word addresses 0,1,2,3,4,3,4,15 gives 4 misses and 4 hits.
- R10: Only one request is outstanding at a time. `cpu_ready` is 0 from acceptance until completion, and `cpu_rvalid` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_ready | output | 1 | Controller can accept a request |
| cpu_rvalid | output | 1 | Load data valid (one-cycle pulse) |
| cpu_rdata | output | DATA_W | Load data |
| mem_rd_req | output | 1 | Line fetch request pulse |
| mem_rd_addr | output | ADDR_W | Line-aligned fetch byte address |
| mem_rd_valid | input | 1 | Refill beat valid |
| mem_rd_word | input | WSEL_W | Word position of the refill beat |
| mem_rd_data | input | DATA_W | Refill beat data |
| mem_wr_valid | output | 1 | Write-through pulse |
| mem_wr_addr | output | ADDR_W | Write-through byte address, bits [1:0] zero |
| mem_wr_data | output | DATA_W | Write-through data |
| hit_count | output | CNT_W | Lookup hit counter (wraps) |
| miss_count | output | CNT_W | Lookup miss counter (wraps) |

## Verification
The assertions rely on three properties of the inputs. The next level answers each fetch with exactly one beat per word position, the write-through port takes a store on every cycle, and refill beats arrive only while a fetch is outstanding. The bench drives the refill port from the read task itself. After each `mem_rd_req` it sends one beat per word position, in sequential, requested-word-first or reverse order, sometimes with idle gaps between beats. It never raises `cpu_req` unless the block is idle. A bench memory model absorbs every write-through, which stands in for a next level that never stalls.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_FILL   = 2'd2
  } dmc_state_e;

  function automatic int unsigned dmc_tag_width(input int unsigned addr_w,
                                                input int unsigned index_w,
                                                input int unsigned wsel_w,
                                                input int unsigned bofs_w);
    return addr_w - index_w - wsel_w - bofs_w;
  endfunction
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int INDEX_W = 8,
  parameter int TAG_W   = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  logic [INDEX_W-1:0] rd_index,
  output logic [TAG_W-1:0]   rd_tag,
  output logic               rd_valid,
  input  logic               set_en,
  input  logic               clr_en,
  input  logic [INDEX_W-1:0] wr_index,
  input  logic [TAG_W-1:0]   wr_tag
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_mem [LINES];

  // tag array: plain synchronous RAM, no reset
  always_ff @(posedge clk) begin
    if (set_en) tag_mem[wr_index] <= wr_tag;
    if (rd_en)  rd_tag <= tag_mem[rd_index];
  end

  // valid flags live in flops so reset clears them all at once
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (set_en)      valid_q[wr_index] <= 1'b1;
      else if (clr_en) valid_q[wr_index] <= 1'b0;
      if (rd_en) rd_valid <= valid_q[rd_index];
    end
  end

  // R5: a line is never both completed and dropped in one cycle
  p_set_clr_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(set_en && clr_en));
endmodule

// File: rtl/dmc_data_store.sv
module dmc_data_store #(
  parameter int AW = 10,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/dmc_event_ctr.sv
module dmc_event_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_ev,
  input  logic             miss_ev,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] miss_count
);
  localparam int NUM_EV = 2;

  logic [NUM_EV-1:0] ev;
  logic [CNT_W-1:0]  cnt_q [NUM_EV];

  assign ev = {miss_ev, hit_ev};

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (rst)        cnt_q[g] <= '0;
      else if (ev[g]) cnt_q[g] <= cnt_q[g] + 1'b1;
    end
  end

  assign hit_count  = cnt_q[0];
  assign miss_count = cnt_q[1];

  // R9: a lookup is either a hit or a miss, never both
  p_one_event_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hit_ev, miss_ev}));

  // R9: counters move by exactly the events of the previous cycle
  p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (hit_count == $past(hit_count) + CNT_W'($past(hit_ev)))
                 && (miss_count == $past(miss_count) + CNT_W'($past(miss_ev))));
endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
  import dmc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int INDEX_W = 8,
  parameter int WSEL_W  = 2,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [WSEL_W-1:0] mem_rd_word,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_valid,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int BOFS_W = $clog2(DATA_W / 8);
  localparam int TAG_W  = int'(dmc_tag_width(ADDR_W, INDEX_W, WSEL_W, BOFS_W));
  localparam int DAW    = INDEX_W + WSEL_W;
  localparam int LOW_W  = WSEL_W + BOFS_W;
  localparam logic [WSEL_W-1:0] LAST_BEAT = {WSEL_W{1'b1}};

  dmc_state_e state_q;

  // incoming address fields
  logic [INDEX_W-1:0] a_idx;
  logic [WSEL_W-1:0]  a_wsel;
  assign a_idx  = cpu_addr[BOFS_W+WSEL_W +: INDEX_W];
  assign a_wsel = cpu_addr[BOFS_W +: WSEL_W];

  // captured request
  logic [ADDR_W-1:0] req_addr_q;
  logic              req_we_q;
  logic [DATA_W-1:0] req_wdata_q;
  logic [TAG_W-1:0]  q_tag;
  logic [INDEX_W-1:0] q_idx;
  logic [WSEL_W-1:0] q_wsel;
  assign q_tag  = req_addr_q[ADDR_W-1 -: TAG_W];
  assign q_idx  = req_addr_q[BOFS_W+WSEL_W +: INDEX_W];
  assign q_wsel = req_addr_q[BOFS_W +: WSEL_W];

  logic accept;
  assign accept    = cpu_req && (state_q == ST_IDLE);
  assign cpu_ready = (state_q == ST_IDLE);

  // stores
  logic [TAG_W-1:0]  tag_rd;
  logic              tag_rd_valid;
  logic              tag_set, tag_clr;
  logic              ram_en, ram_we;
  logic [DAW-1:0]    ram_addr;
  logic [DATA_W-1:0] ram_wdata, ram_rdata;

  logic              lookup_hit;
  logic              last_beat;
  logic [WSEL_W-1:0] beat_cnt_q;
  logic [DATA_W-1:0] fill_word_q;

  assign lookup_hit = tag_rd_valid && (tag_rd == q_tag);
  assign last_beat  = mem_rd_valid && (beat_cnt_q == LAST_BEAT);
  assign tag_set    = (state_q == ST_FILL) && last_beat;
  assign tag_clr    = (state_q == ST_LOOKUP) && !req_we_q && !lookup_hit;

  dmc_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .rd_en    (accept),
    .rd_index (a_idx),
    .rd_tag   (tag_rd),
    .rd_valid (tag_rd_valid),
    .set_en   (tag_set),
    .clr_en   (tag_clr),
    .wr_index (q_idx),
    .wr_tag   (q_tag)
  );

  // single data RAM port, shared by lookup read, store hit and refill
  always_comb begin
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = {a_idx, a_wsel};
    ram_wdata = req_wdata_q;
    unique case (state_q)
      ST_IDLE: ram_en = accept;
      ST_LOOKUP: begin
        if (req_we_q && lookup_hit) begin
          ram_en   = 1'b1;
          ram_we   = 1'b1;
          ram_addr = {q_idx, q_wsel};
        end
      end
      ST_FILL: begin
        if (mem_rd_valid) begin
          ram_en    = 1'b1;
          ram_we    = 1'b1;
          ram_addr  = {q_idx, mem_rd_word};
          ram_wdata = mem_rd_data;
        end
      end
      default: ram_en = 1'b0;
    endcase
  end

  dmc_data_store #(.AW(DAW), .DW(DATA_W)) u_data (
    .clk   (clk),
    .en    (ram_en),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata),
    .rdata (ram_rdata)
  );

  dmc_event_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .hit_ev     ((state_q == ST_LOOKUP) && lookup_hit),
    .miss_ev    ((state_q == ST_LOOKUP) && !lookup_hit),
    .hit_count  (hit_count),
    .miss_count (miss_count)
  );

  // request capture: no reset needed on datapath registers
  always_ff @(posedge clk) begin
    if (accept) begin
      req_addr_q  <= cpu_addr;
      req_we_q    <= cpu_we;
      req_wdata_q <= cpu_wdata;
    end
    if (state_q == ST_FILL && mem_rd_valid && mem_rd_word == q_wsel)
      fill_word_q <= mem_rd_data;
  end

  // control FSM with registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      cpu_rvalid   <= 1'b0;
      cpu_rdata    <= '0;
      mem_rd_req   <= 1'b0;
      mem_rd_addr  <= '0;
      mem_wr_valid <= 1'b0;
      mem_wr_addr  <= '0;
      mem_wr_data  <= '0;
      beat_cnt_q   <= '0;
    end else begin
      cpu_rvalid   <= 1'b0;
      mem_rd_req   <= 1'b0;
      mem_wr_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) state_q <= ST_LOOKUP;
        ST_LOOKUP: begin
          if (req_we_q) begin
            mem_wr_valid <= 1'b1;
            mem_wr_addr  <= {req_addr_q[ADDR_W-1:BOFS_W], {BOFS_W{1'b0}}};
            mem_wr_data  <= req_wdata_q;
            state_q      <= ST_IDLE;
          end else if (lookup_hit) begin
            cpu_rvalid <= 1'b1;
            cpu_rdata  <= ram_rdata;
            state_q    <= ST_IDLE;
          end else begin
            mem_rd_req  <= 1'b1;
            mem_rd_addr <= {q_tag, q_idx, {LOW_W{1'b0}}};
            beat_cnt_q  <= '0;
            state_q     <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_rd_valid) begin
            beat_cnt_q <= beat_cnt_q + 1'b1;
            if (last_beat) begin
              cpu_rvalid <= 1'b1;
              cpu_rdata  <= (mem_rd_word == q_wsel) ? mem_rd_data : fill_word_q;
              state_q    <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: a load response coincides with the controller being free again
  p_resp_idle_r3: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |-> (cpu_ready && !mem_wr_valid && !mem_rd_req));

  // R4: while a fetch is requested the processor is held
  p_miss_stall_r4: assert property (@(posedge clk) disable iff (rst)
    mem_rd_req |-> !cpu_ready);

  // R6: every write-through stems from a store accepted two edges before
  p_wt_source_r6: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> $past(cpu_req && cpu_we && cpu_ready, 2));

  // R6: write-through address is the store address, word aligned
  p_wt_addr_r6: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> (mem_wr_addr[ADDR_W-1:BOFS_W] == $past(cpu_addr[ADDR_W-1:BOFS_W], 2)
                      && mem_wr_addr[BOFS_W-1:0] == '0));

  // R10: load data valid is a single-cycle pulse
  p_rvalid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    cpu_rvalid |=> !cpu_rvalid);

  // R10: an accepted request makes the controller busy on the next cycle
  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_ready) |=> !cpu_ready);
endmodule

// File: tb/dmc_cache_test.sv
module dmc_cache_test;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int INDEX_W = 1;
  localparam int WSEL_W  = 1;
  localparam int CNT_W   = 16;
  localparam int LINES   = 1 << INDEX_W;
  localparam int WPL     = 1 << WSEL_W;
  localparam int MEMW    = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req = 1'b0, cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic cpu_ready, cpu_rvalid;
  logic [DATA_W-1:0] cpu_rdata;
  logic mem_rd_req;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic mem_rd_valid = 1'b0;
  logic [WSEL_W-1:0] mem_rd_word = '0;
  logic [DATA_W-1:0] mem_rd_data = '0;
  logic mem_wr_valid;
  logic [ADDR_W-1:0] mem_wr_addr;
  logic [DATA_W-1:0] mem_wr_data;
  logic [CNT_W-1:0] hit_count, miss_count;

  always #10 clk = ~clk;  // 50 MHz

  dmc_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W),
              .WSEL_W(WSEL_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_word(mem_rd_word), .mem_rd_data(mem_rd_data),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .hit_count(hit_count), .miss_count(miss_count)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int exp_hits = 0;
  int exp_misses = 0;

  logic [DATA_W-1:0] mem_model [MEMW];
  bit                mdl_valid [LINES];
  int                mdl_tag   [LINES];

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic int idx_of(input int w);
    return (w >> WSEL_W) % LINES;
  endfunction
  function automatic int tag_of(input int w);
    return w >> (WSEL_W + INDEX_W);
  endfunction

  task automatic check_counters(input string rq);
    chk({rq, " hit_count"}, 32'(hit_count), 32'(exp_hits));
    chk({rq, " miss_count"}, 32'(miss_count), 32'(exp_misses));
  endtask

  // read one word; order 0 sequential, 1 requested word first, 2 reverse
  task automatic do_read(input int waddr, input int order, input bit gap, input logic [1:0] low);
    int  ix = idx_of(waddr);
    bit  ehit = mdl_valid[ix] && (mdl_tag[ix] == tag_of(waddr));
    int  base = (waddr >> WSEL_W) << WSEL_W;
    int  ws = waddr % WPL;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = ADDR_W'(waddr * 4) | ADDR_W'(low);
    @(negedge clk);
    cpu_req = 1'b0;
    chk("R10 busy after accept", 32'(cpu_ready), 32'd0);
    @(negedge clk);
    if (ehit) begin
      exp_hits++;
      chk("R3 hit rvalid", 32'(cpu_rvalid), 32'd1);
      chk("R3 hit rdata", cpu_rdata, mem_model[waddr]);
      chk("R3 hit no fetch", 32'(mem_rd_req), 32'd0);
    end else begin
      exp_misses++;
      chk("R4 miss fetch req", 32'(mem_rd_req), 32'd1);
      chk("R4 fetch addr", mem_rd_addr, 32'(base * 4));
      chk("R4 no early rvalid", 32'(cpu_rvalid), 32'd0);
      for (int b = 0; b < WPL; b++) begin
        int w = (order == 0) ? b : (order == 1) ? (ws + b) % WPL : WPL - 1 - b;
        if (gap) begin
          mem_rd_valid = 1'b0;
          @(negedge clk);
          chk("R4 stall during gap", 32'(cpu_ready), 32'd0);
        end
        chk("R5 no response before last beat", 32'(cpu_rvalid), 32'd0);
        chk("R4 stalled during fill", 32'(cpu_ready), 32'd0);
        mem_rd_valid = 1'b1;
        mem_rd_word  = WSEL_W'(w);
        mem_rd_data  = mem_model[base + w];
        @(negedge clk);
      end
      mem_rd_valid = 1'b0;
      chk("R5 refill rvalid", 32'(cpu_rvalid), 32'd1);
      chk("R5 refill rdata", cpu_rdata, mem_model[waddr]);
      chk("R5 ready after refill", 32'(cpu_ready), 32'd1);
      mdl_valid[ix] = 1'b1;
      mdl_tag[ix]   = tag_of(waddr);
    end
    @(negedge clk);
    chk("R10 rvalid single pulse", 32'(cpu_rvalid), 32'd0);
  endtask

  task automatic do_write(input int waddr, input logic [31:0] data);
    int ix = idx_of(waddr);
    bit ehit = mdl_valid[ix] && (mdl_tag[ix] == tag_of(waddr));
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = ADDR_W'(waddr * 4) | 32'd2; cpu_wdata = data;
    @(negedge clk);
    cpu_req = 1'b0; cpu_we = 1'b0;
    @(negedge clk);
    if (ehit) exp_hits++; else exp_misses++;
    chk(ehit ? "R6 wt valid" : "R7 wt valid", 32'(mem_wr_valid), 32'd1);
    chk(ehit ? "R6 wt addr" : "R7 wt addr", mem_wr_addr, 32'(waddr * 4));
    chk(ehit ? "R6 wt data" : "R7 wt data", mem_wr_data, data);
    chk("R7 no fetch on store", 32'(mem_rd_req), 32'd0);
    chk("R6 ready after store", 32'(cpu_ready), 32'd1);
    mem_model[waddr] = data;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < LINES; i++) mdl_valid[i] = 1'b0;
    exp_hits = 0; exp_misses = 0;
    @(negedge clk);
    chk("R2 ready", 32'(cpu_ready), 32'd1);
    chk("R2 rvalid", 32'(cpu_rvalid), 32'd0);
    chk("R2 fetch idle", 32'(mem_rd_req), 32'd0);
    chk("R2 wt idle", 32'(mem_wr_valid), 32'd0);
    check_counters("R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    int m0;
    for (int i = 0; i < MEMW; i++) mem_model[i] = 32'hC0DE_0000 + 32'(i * 32'h0101_0003);
    do_reset();

    // R9 reference string on two lines of two words
    do_read(0, 0, 0, 2'd0); do_read(1, 0, 0, 2'd0); do_read(2, 1, 1, 2'd0);
    do_read(3, 0, 0, 2'd0); do_read(4, 2, 0, 2'd0); do_read(3, 0, 0, 2'd0);
    do_read(4, 0, 0, 2'd0); do_read(15, 1, 1, 2'd0);
    chk("R9 reference string misses", 32'(miss_count), 32'd4);
    chk("R9 reference string hits", 32'(hit_count), 32'd4);
    check_counters("R9");

    // R8 ping-pong between word 0 and word 4 (same index)
    m0 = exp_misses;
    for (int k = 0; k < 8; k++) do_read((k % 2) * 4, k % 3, k[0], 2'd0);
    chk("R8 ping-pong all miss", 32'(exp_misses - m0), 32'd8);
    check_counters("R8");

    // R1 byte offset ignored: word 4 cached, read with offset 3
    do_read(4, 0, 0, 2'd3);
    do_read(5, 0, 0, 2'd1);
    check_counters("R1");

    // R6 write hit then read back
    do_write(4, 32'hDEAD_BEEF);
    do_read(4, 0, 0, 2'd0);
    check_counters("R6");

    // R7 write miss: no allocation, old line kept
    do_write(9, 32'h1234_5678);
    m0 = exp_misses;
    do_read(5, 0, 0, 2'd0);
    chk("R7 old line still hits", 32'(exp_misses - m0), 32'd0);
    do_read(9, 1, 0, 2'd0);
    chk("R7 written word misses", 32'(exp_misses - m0), 32'd1);
    check_counters("R7");

    // sweep over a small address range, mixed loads and stores
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      int wa;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      wa = int'(lfsr[4:0]);
      if (lfsr[9:8] == 2'b00) do_write(wa, {lfsr, 16'(n)});
      else do_read(wa, n % 3, lfsr[6], lfsr[11:10]);
    end
    check_counters("R9 sweep");

    // R2 reset invalidates all lines
    do_reset();
    do_read(15, 0, 0, 2'd0);
    chk("R2 first access after reset misses", 32'(miss_count), 32'd1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule